// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Set

This block is the register file that software uses to drive one channel of an IDE-style storage controller's bus-master DMA. It holds a command byte, a status byte, two spare bytes and a 32-bit descriptor-table pointer in an eight-byte window. Writes are decoded by offset and access size, and each register has its own write rules.

Toggling the run bit in the command byte launches or cancels a transfer. A launch sends a one-cycle start strobe to an external DMA engine, together with a copy of the pointer. A cancel sends a one-cycle abort strobe. The engine reports the end of a transfer on `dma_done`, with `dma_fault` marking a failed transfer. The interrupt line is the level of the interrupt-status bit, and software clears that bit by writing a 1 to it.

Layout: the command byte is at offset 0 (bit 0 run, bit 3 direction). Spare bytes are at offsets 1 and 3. The status byte is at offset 2 (bit 0 active, bit 1 error, bit 2 interrupt, bits 5 and 6 drive-0 and drive-1 DMA capable). The pointer is at offset 4. Size codes are 0 for a byte, 1 for a halfword and 2 for a dword.

Top module: `bmide_chan_regs`

## Requirements
- R1: After synchronous reset, the low read word is 32'h0060_0000: command 0, status 0x60 (only the two capability bits set), spare bytes 0. The pointer reads 0, and `irq`, `start_pulse`, `abort_pulse`, `size_err` and `nodev_err` are all 0.
- R2: A byte write to offset 0 that moves the run bit (bit 0) from 0 to 1 while `dev_present` is 1 has three effects. It sets status bit 0 (active). It raises `start_pulse` for exactly one cycle. It loads `dma_ptr` with the stored pointer. `dma_ptr` changes at no other time.
- R3: A byte write to offset 0 that moves the run bit from 1 to 0 while `dev_present` is 1 clears the active bit and raises `abort_pulse` for exactly one cycle.
- R4: A run-bit change requested while `dev_present` is 0 raises `nodev_err` for one cycle. It leaves the command byte and the active bit unchanged and gives no start or abort strobe.
- R5: Status bit 0 (active) ignores software writes.
- R6: Status bit 1 (error) and bit 2 (interrupt) clear only when a status write carries a 1 in that position; a 0 leaves them as they are. Status bits 7..3 take the written value.
- R7: `dma_done` clears the run bit and the active bit and sets the interrupt bit. With `dma_fault` also high, it sets the error bit. If a command write arrives in the same cycle, `dma_done` wins for the run and active bits, and no strobe is issued.
- R8: The pointer accepts only dword writes at offset 4, and it stores the value with bits 1:0 forced to 0.
- R9: A write with a size or offset not allowed for the target changes no register and raises `size_err` for one cycle. The allowed writes are byte writes to offsets 0..3 and dword writes to offset 4; offsets 5..7 accept no write.
- R10: A read returns data on `rdata` one cycle after `rd_en`. An address with bit 2 clear returns {byte3, status, byte1, command}, little-endian. An address with bit 2 set returns the pointer.
- R11: `irq` follows the interrupt-status bit (status bit 2).
- R12: A command write that leaves the run bit unchanged stores the other bits (such as direction, bit 3) and issues no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | ADDR_W | Byte offset within the channel window |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 dword |
| wdata | input | 32 | Write data, byte writes on bits 7:0 |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| dev_present | input | 1 | A drive is selected on this channel |
| dma_done | input | 1 | Transfer-complete indication from the DMA engine |
| dma_fault | input | 1 | Qualifies dma_done as a failed transfer |
| start_pulse | output | 1 | One-cycle request to start a transfer |
| abort_pulse | output | 1 | One-cycle request to abort a transfer |
| dma_ptr | output | PTR_W | Pointer captured at the last start |
| irq | output | 1 | Interrupt level |
| size_err | output | 1 | One-cycle strobe for a disallowed write |
| nodev_err | output | 1 | One-cycle strobe for a run change with no drive |

## Verification
Every write takes effect at the clock edge that samples it. The strobes, `dma_ptr`, `irq` and the register contents are therefore due in the cycle right after that edge, and a read result appears one edge after `rd_en`. The bench drives inputs on the falling edge. Each write task samples the strobes on the next falling edge and checks one cycle later that they have dropped. Each expected read word goes into a queue, and a monitor pops it on the falling edge after the capturing rising edge.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int DATA_W = 32;

  // byte offsets inside the channel window
  localparam int OFF_CMD  = 0;
  localparam int OFF_RSV1 = 1;
  localparam int OFF_STS  = 2;
  localparam int OFF_RSV3 = 3;
  localparam int OFF_PTR  = 4;

  // command byte bits
  localparam int CMD_RUN = 0;

  // status byte bits
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_IRQ  = 2;
  localparam logic [7:0] ST_PLAIN_MASK = 8'hF8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/bmc_decode.sv
module bmc_decode #(
  parameter int ADDR_W = 3
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              we_cmd,
  output logic              we_sts,
  output logic              we_rsv1,
  output logic              we_rsv3,
  output logic              we_ptr,
  output logic              bad_wr
);
  import bmc_pkg::*;

  logic is_byte, is_word;
  assign is_byte = (size == SZ_BYTE);
  assign is_word = (size == SZ_WORD);

  always_comb begin
    we_cmd  = 1'b0;
    we_sts  = 1'b0;
    we_rsv1 = 1'b0;
    we_rsv3 = 1'b0;
    we_ptr  = 1'b0;
    bad_wr  = 1'b0;
    if (wr_en) begin
      if (addr == ADDR_W'(OFF_CMD)) begin
        if (is_byte) we_cmd = 1'b1; else bad_wr = 1'b1;
      end else if (addr == ADDR_W'(OFF_RSV1)) begin
        if (is_byte) we_rsv1 = 1'b1; else bad_wr = 1'b1;
      end else if (addr == ADDR_W'(OFF_STS)) begin
        if (is_byte) we_sts = 1'b1; else bad_wr = 1'b1;
      end else if (addr == ADDR_W'(OFF_RSV3)) begin
        if (is_byte) we_rsv3 = 1'b1; else bad_wr = 1'b1;
      end else if (addr == ADDR_W'(OFF_PTR)) begin
        if (is_word) we_ptr = 1'b1; else bad_wr = 1'b1;
      end else begin
        bad_wr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bmc_ctl.sv
module bmc_ctl #(
  parameter logic [1:0] CAP_RESET = 2'b11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we_cmd,
  input  logic       we_sts,
  input  logic       we_rsv1,
  input  logic       we_rsv3,
  input  logic       bad_wr,
  input  logic [7:0] wbyte,
  input  logic       dev_present,
  input  logic       dma_done,
  input  logic       dma_fault,
  output logic [7:0] cmd_q,
  output logic [7:0] sts_q,
  output logic [7:0] rsv1_q,
  output logic [7:0] rsv3_q,
  output logic       launch,
  output logic       start_o,
  output logic       abort_o,
  output logic       nodev_o,
  output logic       sizeerr_o
);
  import bmc_pkg::*;

  localparam logic [7:0] STS_RESET = {1'b0, CAP_RESET, 5'b0};

  logic run_old, run_edge, refused, go;
  logic [7:0] cmd_n, sts_n;

  assign run_old  = cmd_q[CMD_RUN];
  assign run_edge = we_cmd && (wbyte[CMD_RUN] != run_old);
  assign refused  = run_edge && !dev_present;
  assign go       = run_edge && dev_present && !dma_done;
  assign launch   = go && !run_old;

  always_comb begin
    cmd_n = cmd_q;
    if (we_cmd && !refused) cmd_n = wbyte;
    if (dma_done) cmd_n[CMD_RUN] = 1'b0;

    sts_n = sts_q;
    if (we_sts) begin
      sts_n = (sts_q & ~ST_PLAIN_MASK) | (wbyte & ST_PLAIN_MASK);
      if (wbyte[ST_ERR]) sts_n[ST_ERR] = 1'b0;
      if (wbyte[ST_IRQ]) sts_n[ST_IRQ] = 1'b0;
    end
    if (go) sts_n[ST_ACT] = !run_old;
    if (dma_done) begin
      sts_n[ST_ACT] = 1'b0;
      sts_n[ST_IRQ] = 1'b1;
      if (dma_fault) sts_n[ST_ERR] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      sts_q     <= STS_RESET;
      rsv1_q    <= '0;
      rsv3_q    <= '0;
      start_o   <= 1'b0;
      abort_o   <= 1'b0;
      nodev_o   <= 1'b0;
      sizeerr_o <= 1'b0;
    end else begin
      cmd_q     <= cmd_n;
      sts_q     <= sts_n;
      if (we_rsv1) rsv1_q <= wbyte;
      if (we_rsv3) rsv3_q <= wbyte;
      start_o   <= go && !run_old;
      abort_o   <= go && run_old;
      nodev_o   <= refused;
      sizeerr_o <= bad_wr;
    end
  end
endmodule

// File: rtl/bmc_ptr.sv
module bmc_ptr #(
  parameter int PTR_W     = 32,
  parameter int PTR_ALIGN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PTR_W-1:0] wdata,
  input  logic             launch,
  output logic [PTR_W-1:0] ptr_q,
  output logic [PTR_W-1:0] ptr_out
);
  localparam logic [PTR_W-1:0] KEEP_MASK =
    {{(PTR_W-PTR_ALIGN){1'b1}}, {PTR_ALIGN{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      ptr_out <= '0;
    end else begin
      if (we)     ptr_q   <= wdata & KEEP_MASK;
      if (launch) ptr_out <= ptr_q;
    end
  end
endmodule

// File: rtl/bmc_rdmux.sv
module bmc_rdmux #(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             sel_ptr,
  input  logic [7:0]       cmd_q,
  input  logic [7:0]       rsv1_q,
  input  logic [7:0]       sts_q,
  input  logic [7:0]       rsv3_q,
  input  logic [PTR_W-1:0] ptr_q,
  output logic [31:0]      rdata
);
  logic [31:0] ptr_ext, lo_word;

  generate
    if (PTR_W < 32) begin : g_ext
      assign ptr_ext = {{(32-PTR_W){1'b0}}, ptr_q};
    end else begin : g_full
      assign ptr_ext = ptr_q[31:0];
    end
  endgenerate

  assign lo_word = {rsv3_q, sts_q, rsv1_q, cmd_q};

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel_ptr ? ptr_ext : lo_word;
  end
endmodule

// File: rtl/bmide_chan_regs.sv
module bmide_chan_regs #(
  parameter int         ADDR_W    = 3,
  parameter int         PTR_W     = 32,
  parameter int         PTR_ALIGN = 2,
  parameter logic [1:0] CAP_RESET = 2'b11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              dev_present,
  input  logic              dma_done,
  input  logic              dma_fault,
  output logic              start_pulse,
  output logic              abort_pulse,
  output logic [PTR_W-1:0]  dma_ptr,
  output logic              irq,
  output logic              size_err,
  output logic              nodev_err
);
  import bmc_pkg::*;

  logic we_cmd, we_sts, we_rsv1, we_rsv3, we_ptr, bad_wr, launch;
  logic [7:0] cmd_q, sts_q, rsv1_q, rsv3_q;
  logic [PTR_W-1:0] ptr_q;

  bmc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .addr(addr), .size(size),
    .we_cmd(we_cmd), .we_sts(we_sts), .we_rsv1(we_rsv1),
    .we_rsv3(we_rsv3), .we_ptr(we_ptr), .bad_wr(bad_wr)
  );

  bmc_ctl #(.CAP_RESET(CAP_RESET)) u_ctl (
    .clk(clk), .rst(rst),
    .we_cmd(we_cmd), .we_sts(we_sts), .we_rsv1(we_rsv1), .we_rsv3(we_rsv3),
    .bad_wr(bad_wr), .wbyte(wdata[7:0]),
    .dev_present(dev_present), .dma_done(dma_done), .dma_fault(dma_fault),
    .cmd_q(cmd_q), .sts_q(sts_q), .rsv1_q(rsv1_q), .rsv3_q(rsv3_q),
    .launch(launch), .start_o(start_pulse), .abort_o(abort_pulse),
    .nodev_o(nodev_err), .sizeerr_o(size_err)
  );

  bmc_ptr #(.PTR_W(PTR_W), .PTR_ALIGN(PTR_ALIGN)) u_ptr (
    .clk(clk), .rst(rst), .we(we_ptr), .wdata(wdata[PTR_W-1:0]),
    .launch(launch), .ptr_q(ptr_q), .ptr_out(dma_ptr)
  );

  bmc_rdmux #(.PTR_W(PTR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel_ptr(addr[2]),
    .cmd_q(cmd_q), .rsv1_q(rsv1_q), .sts_q(sts_q), .rsv3_q(rsv3_q),
    .ptr_q(ptr_q), .rdata(rdata)
  );

  assign irq = sts_q[ST_IRQ];
endmodule

// File: rtl/bmc_chk.sv
module bmc_chk #(
  parameter int PTR_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             dev_present,
  input logic             dma_done,
  input logic             start_pulse,
  input logic             abort_pulse,
  input logic [PTR_W-1:0] dma_ptr,
  input logic             irq,
  input logic             size_err,
  input logic             nodev_err
);
  // R2
  start_needs_dev_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> ($past(wr_en) && $past(dev_present) && !$past(dma_done)));

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start_pulse |-> $stable(dma_ptr));

  // R3
  abort_needs_dev_chk: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |-> ($past(wr_en) && $past(dev_present)));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_pulse, abort_pulse, nodev_err}));

  // R4
  nodev_cause_chk: assert property (@(posedge clk) disable iff (rst)
    nodev_err |-> ($past(wr_en) && !$past(dev_present)));

  // R7
  done_sets_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $past(dma_done) && !$past(rst) |-> irq);

  // R9
  size_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    size_err |-> $past(wr_en));

  // R11
  irq_clear_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(wr_en));
endmodule

bind bmide_chan_regs bmc_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .dev_present(dev_present),
  .dma_done(dma_done), .start_pulse(start_pulse), .abort_pulse(abort_pulse),
  .dma_ptr(dma_ptr), .irq(irq), .size_err(size_err), .nodev_err(nodev_err)
);

// File: tb/bmide_chan_regs_test.sv
module bmide_chan_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dev_present = 1'b0, dma_done = 1'b0, dma_fault = 1'b0;
  logic        start_pulse, abort_pulse, irq, size_err, nodev_err;
  logic [31:0] dma_ptr;

  int total = 0;
  int bad = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        mon_pending = 1'b0;

  logic s_start, s_abort, s_size, s_nodev;

  bmide_chan_regs uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .size(size), .wdata(wdata), .rdata(rdata), .dev_present(dev_present),
    .dma_done(dma_done), .dma_fault(dma_fault), .start_pulse(start_pulse),
    .abort_pulse(abort_pulse), .dma_ptr(dma_ptr), .irq(irq),
    .size_err(size_err), .nodev_err(nodev_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read words
  always @(posedge clk) mon_pending <= rd_en;
  always @(negedge clk) begin
    if (mon_pending) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R10 unexpected read data actual=%h expected=none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic do_read(input logic [2:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [1:0] sz, input logic [31:0] d,
                          input logic done, input logic fault);
    wr_en = 1'b1; addr = a; size = sz; wdata = d; dma_done = done; dma_fault = fault;
    @(negedge clk);
    wr_en = 1'b0; dma_done = 1'b0; dma_fault = 1'b0;
    s_start = start_pulse; s_abort = abort_pulse; s_size = size_err; s_nodev = nodev_err;
    @(negedge clk);
    check("R2 strobes drop after one cycle", {28'd0, start_pulse, abort_pulse, size_err, nodev_err}, 32'd0);
  endtask

  task automatic strobes(input string tag, input logic st, input logic ab, input logic se, input logic nd);
    check(tag, {28'd0, s_start, s_abort, s_size, s_nodev}, {28'd0, st, ab, se, nd});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    check("R1 strobes after reset", {28'd0, start_pulse, abort_pulse, size_err, nodev_err}, 32'd0);
    do_read(3'd0, 32'h0060_0000, "R1 low word after reset");
    do_read(3'd4, 32'h0, "R1 pointer after reset");

    // R8 pointer alignment
    do_write(3'd4, 2'd2, 32'h1234_5677, 1'b0, 1'b0);
    strobes("R8 pointer write strobes", 1'b0, 1'b0, 1'b0, 1'b0);
    do_read(3'd4, 32'h1234_5674, "R8 pointer low bits forced to zero");

    // R9 illegal writes
    do_write(3'd4, 2'd0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    strobes("R9 byte write to pointer", 1'b0, 1'b0, 1'b1, 1'b0);
    do_write(3'd0, 2'd1, 32'h0000_0001, 1'b0, 1'b0);
    strobes("R9 halfword write to command", 1'b0, 1'b0, 1'b1, 1'b0);
    do_write(3'd6, 2'd0, 32'h0000_00FF, 1'b0, 1'b0);
    strobes("R9 write to unused offset", 1'b0, 1'b0, 1'b1, 1'b0);
    do_read(3'd4, 32'h1234_5674, "R9 pointer unchanged");
    do_read(3'd0, 32'h0060_0000, "R9 command unchanged");

    // R2 start
    dev_present = 1'b1;
    do_write(3'd0, 2'd0, 32'h0000_0009, 1'b0, 1'b0);
    strobes("R2 start strobe", 1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 dma_ptr carries pointer", dma_ptr, 32'h1234_5674);
    do_read(3'd0, 32'h0061_0009, "R2 active set");

    // R5 active read-only
    do_write(3'd2, 2'd0, 32'h0000_0060, 1'b0, 1'b0);
    do_read(3'd0, 32'h0061_0009, "R5 active ignores write");

    // R12 no-edge command writes
    do_write(3'd0, 2'd0, 32'h0000_0009, 1'b0, 1'b0);
    strobes("R12 same run value no strobe", 1'b0, 1'b0, 1'b0, 1'b0);
    do_write(3'd0, 2'd0, 32'h0000_0001, 1'b0, 1'b0);
    strobes("R12 direction change no strobe", 1'b0, 1'b0, 1'b0, 1'b0);
    do_read(3'd0, 32'h0061_0001, "R12 direction bit stored");

    // R3 stop
    do_write(3'd0, 2'd0, 32'h0000_0000, 1'b0, 1'b0);
    strobes("R3 abort strobe", 1'b0, 1'b1, 1'b0, 1'b0);
    do_read(3'd0, 32'h0060_0000, "R3 active cleared");

    // R7 completion with fault
    do_write(3'd4, 2'd2, 32'h0000_1000, 1'b0, 1'b0);
    do_write(3'd0, 2'd0, 32'h0000_0001, 1'b0, 1'b0);
    strobes("R2 second start", 1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 dma_ptr updated", dma_ptr, 32'h0000_1000);
    dma_done = 1'b1; dma_fault = 1'b1;
    @(negedge clk);
    dma_done = 1'b0; dma_fault = 1'b0;
    check("R11 irq after completion", {31'd0, irq}, 32'd1);
    do_read(3'd0, 32'h0066_0000, "R7 completion clears run/active, sets irq and error");

    // R6 write-1-to-clear
    do_write(3'd2, 2'd0, 32'h0000_0060, 1'b0, 1'b0);
    do_read(3'd0, 32'h0066_0000, "R6 zeros leave irq and error");
    do_write(3'd2, 2'd0, 32'h0000_0064, 1'b0, 1'b0);
    check("R11 irq follows cleared bit", {31'd0, irq}, 32'd0);
    do_read(3'd0, 32'h0062_0000, "R6 irq cleared, error kept");
    do_write(3'd2, 2'd0, 32'h0000_0082, 1'b0, 1'b0);
    do_read(3'd0, 32'h0080_0000, "R6 error cleared, plain bits written");
    do_write(3'd2, 2'd0, 32'h0000_0060, 1'b0, 1'b0);

    // R4 no device
    dev_present = 1'b0;
    do_write(3'd0, 2'd0, 32'h0000_0001, 1'b0, 1'b0);
    strobes("R4 refused start", 1'b0, 1'b0, 1'b0, 1'b1);
    do_read(3'd0, 32'h0060_0000, "R4 command and active unchanged");

    // R7 completion wins over same-cycle start
    dev_present = 1'b1;
    do_write(3'd0, 2'd0, 32'h0000_0009, 1'b1, 1'b0);
    strobes("R7 no strobe with completion", 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 irq set", {31'd0, irq}, 32'd1);
    do_read(3'd0, 32'h0064_0008, "R7 run cleared by completion");
    do_write(3'd2, 2'd0, 32'h0000_0064, 1'b0, 1'b0);

    // R10 spare bytes and word layout
    do_write(3'd1, 2'd0, 32'h0000_00A5, 1'b0, 1'b0);
    do_write(3'd3, 2'd0, 32'h0000_003C, 1'b0, 1'b0);
    do_read(3'd2, 32'h3C60_A508, "R10 little-endian low word");
    do_read(3'd7, 32'h0000_1000, "R10 pointer word select");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R10 reads missing actual=%0d expected=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule